// File: doc/BRIEF.md
# Keyed Watchdog Timer with Two-Stage Expiry

This block guards a chip against a hung processor. An 8-bit down-counter is clocked by a slow tick that a free-running prescaler derives from the system clock. With a 100 MHz clock and the default prescaler, the tick rate is close to 763 Hz. Software starts, kicks or stops the counter with a single control write. That write carries a start value, a command bit and a 7-bit key.

A write is honoured only if its key is the bitwise complement of the key in the last write that was honoured. A runaway program that keeps writing the same value therefore cannot keep the chip alive. The first write after reset may use any key.

Expiry happens in two stages. When the count steps down to 1, the block sends a one-cycle non-maskable interrupt request, which gives software one last tick period to react. When the count reaches 0, the block raises a chip reset request. That request stays high until the block itself is reset. Rejected writes set a sticky status flag.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `nmi`, `chip_reset` and `bad_key` are 0 and the watchdog is stopped. With no write, no NMI and no chip reset ever occur.
- R2: The prescaler runs freely from reset and produces one tick every PRESCALE_TC+1 clock cycles. The counter changes only on ticks.
- R3: The first write after reset is accepted whatever its key.
- R4: Every later write is accepted only if its key equals the previously accepted key XOR 7'h7F. Any other write changes nothing in the counter or the stored key, and it sets `bad_key`, which stays 1 until reset.
- R5: An accepted write with `wr_cmd`=1 (start) loads `wr_count` and runs the counter. If the counter is already running, the same write reloads it as a kick.
- R6: On a tick that moves a running count from 2 to 1, `nmi` is 1 for exactly one clock cycle.
- R7: On a tick that finds a running count of 1 or less, the count becomes 0 and `chip_reset` rises. It then stays 1, and all writes leave it unchanged until `rst`.
- R8: An accepted write with `wr_cmd`=0 (stop) halts counting. A stop whose key is wrong is rejected, so the counter keeps running toward expiry.
- R9: When an accepted write and a tick fall in the same cycle, the write wins and the tick does not decrement.
- R10: Starting with a count of 1 or 0 leads to `chip_reset` on the next tick, with no NMI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control write strobe, one cycle |
| wr_count | input | 8 | Start value for the counter |
| wr_cmd | input | 1 | Command: 1 start/kick, 0 stop |
| wr_key | input | 7 | Key presented with the write |
| nmi | output | 1 | One-cycle non-maskable interrupt request |
| chip_reset | output | 1 | Sticky chip reset request |
| bad_key | output | 1 | Sticky flag: a write was rejected |

## Verification
The bench builds the block with PRESCALE_TC set to 7, so a tick arrives every eight clocks instead of every 131072. At that rate a full expiry, including the NMI stage and the reset stage, fits in a few dozen cycles. It also lets the bench place a write exactly on a tick edge and check that the write takes precedence. With small start values, the reload, stop, key-rejection and immediate-expiry cases all fit in one short run, and the reference model is compared against the outputs on every clock.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int CNT_W = 8;
    localparam int KEY_W = 7;

    typedef enum logic {
        CMD_STOP  = 1'b0,
        CMD_START = 1'b1
    } wdg_cmd_e;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        wdg_cmd_e         cmd;
        logic [KEY_W-1:0] key;
    } wdg_wr_t;

    typedef struct packed {
        logic             running;
        logic             bitten;
        logic [CNT_W-1:0] count;
    } wdg_state_t;

    function automatic logic [KEY_W-1:0] expected_key(input logic [KEY_W-1:0] last);
        return last ^ {KEY_W{1'b1}};
    endfunction

    function automatic int unsigned presc_width(input int unsigned tc);
        return (tc > 0) ? $clog2(tc + 1) : 1;
    endfunction

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int unsigned PRESCALE_TC = 131071
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    import wdg_pkg::*;

    localparam int unsigned PW = presc_width(PRESCALE_TC);

    logic [PW-1:0] pcnt;

    assign tick = (pcnt == PW'(PRESCALE_TC));

    always_ff @(posedge clk) begin
        if (rst)       pcnt <= '0;
        else if (tick) pcnt <= '0;
        else           pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/wdg_key_gate.sv
module wdg_key_gate
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_key,
    output logic             accept,
    output logic             bad_key
);
    logic             key_set;
    logic [KEY_W-1:0] key_q;

    assign accept = wr_en && (!key_set || (wr_key == expected_key(key_q)));

    always_ff @(posedge clk) begin
        if (rst) begin
            key_set <= 1'b0;
            key_q   <= '0;
            bad_key <= 1'b0;
        end else begin
            if (accept) begin
                key_set <= 1'b1;
                key_q   <= wr_key;
            end
            if (wr_en && !accept) bad_key <= 1'b1;
        end
    end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             accept,
    input  wdg_cmd_e         cmd,
    input  logic [CNT_W-1:0] load_val,
    output logic             nmi,
    output logic             bite
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    wdg_state_t st, st_nx;
    logic       nmi_nx;

    always_comb begin
        st_nx  = st;
        nmi_nx = 1'b0;
        if (!st.bitten) begin
            if (accept) begin
                if (cmd == CMD_START) begin
                    st_nx.count   = load_val;
                    st_nx.running = 1'b1;
                end else begin
                    st_nx.running = 1'b0;
                end
            end else if (st.running && tick) begin
                if (st.count <= ONE) begin
                    st_nx.count   = '0;
                    st_nx.bitten  = 1'b1;
                    st_nx.running = 1'b0;
                end else begin
                    st_nx.count = st.count - ONE;
                    nmi_nx      = (st.count == TWO);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= '0;
            nmi <= 1'b0;
        end else begin
            st  <= st_nx;
            nmi <= nmi_nx;
        end
    end

    assign bite = st.bitten;
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
    parameter int unsigned PRESCALE_TC = 131071
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_count,
    input  logic       wr_cmd,
    input  logic [6:0] wr_key,
    output logic       nmi,
    output logic       chip_reset,
    output logic       bad_key
);
    import wdg_pkg::*;

    wdg_wr_t wr;
    logic    tick;
    logic    accept;

    assign wr.count = wr_count;
    assign wr.cmd   = wdg_cmd_e'(wr_cmd);
    assign wr.key   = wr_key;

    wdg_prescaler #(.PRESCALE_TC(PRESCALE_TC)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    wdg_key_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_key  (wr.key),
        .accept  (accept),
        .bad_key (bad_key)
    );

    wdg_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .accept   (accept),
        .cmd      (wr.cmd),
        .load_val (wr.count),
        .nmi      (nmi),
        .bite     (chip_reset)
    );
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic accept,
    input logic wr_en,
    input logic nmi,
    input logic chip_reset,
    input logic bad_key
);
    logic rst_d = 1'b0;

    always_ff @(posedge clk) begin
        if (rst_d) begin
            a_r1_reset_quiet: assert (!nmi && !chip_reset && !bad_key)
                else $error("R1: outputs not clear after reset");
        end
        rst_d <= rst;
    end

    a_r6_nmi_single: assert property (@(posedge clk) disable iff (rst)
        nmi |=> !nmi);

    a_r6_nmi_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi) |-> $past(tick));

    a_r7_reset_sticky: assert property (@(posedge clk) disable iff (rst)
        chip_reset |=> chip_reset);

    a_r7_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(chip_reset) |-> $past(tick) && !$past(accept));

    a_r4_bad_sticky: assert property (@(posedge clk) disable iff (rst)
        bad_key |=> bad_key);

    a_r4_reject_flags: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !accept) |=> bad_key);
endmodule

bind keyed_watchdog keyed_watchdog_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .accept     (accept),
    .wr_en      (wr_en),
    .nmi        (nmi),
    .chip_reset (chip_reset),
    .bad_key    (bad_key)
);

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;
    localparam int TC = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_count = '0;
    logic       wr_cmd = 1'b0;
    logic [6:0] wr_key = '0;
    logic       nmi, chip_reset, bad_key;

    int checks = 0;
    int errors = 0;
    bit nmi_seen = 0;

    // reference model state
    int m_pc = 0, m_cnt = 0;
    bit m_run = 0, m_bite = 0, m_nmi = 0, m_bad = 0, m_kv = 0;
    int m_key = 0;

    always #5 clk = ~clk;

    keyed_watchdog #(.PRESCALE_TC(TC)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_count(wr_count),
        .wr_cmd(wr_cmd), .wr_key(wr_key),
        .nmi(nmi), .chip_reset(chip_reset), .bad_key(bad_key)
    );

    always @(posedge clk) begin
        bit tk, acc;
        if (rst) begin
            m_pc = 0; m_cnt = 0; m_run = 0; m_bite = 0;
            m_nmi = 0; m_bad = 0; m_kv = 0; m_key = 0;
        end else begin
            tk = (m_pc == TC);
            m_pc = tk ? 0 : m_pc + 1;
            m_nmi = 0;
            acc = wr_en && (!m_kv || int'(wr_key) == (m_key ^ 'h7F));
            if (wr_en && !acc) m_bad = 1;
            if (acc) begin m_key = int'(wr_key); m_kv = 1; end
            if (!m_bite) begin
                if (acc) begin
                    if (wr_cmd) begin m_cnt = int'(wr_count); m_run = 1; end
                    else m_run = 0;
                end else if (m_run && tk) begin
                    if (m_cnt <= 1) begin m_cnt = 0; m_bite = 1; m_run = 0; end
                    else begin
                        if (m_cnt == 2) m_nmi = 1;
                        m_cnt = m_cnt - 1;
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R6 R2 nmi vs model", int'(nmi), int'(m_nmi));
            chk("R7 chip_reset vs model", int'(chip_reset), int'(m_bite));
            chk("R4 bad_key vs model", int'(bad_key), int'(m_bad));
            if (nmi) nmi_seen = 1;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        nmi_seen = 0;
    endtask

    task automatic do_write(input int c, input bit start, input int k);
        wr_en = 1'b1; wr_count = c[7:0]; wr_cmd = start; wr_key = k[6:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int k;
        idle(3);
        rst = 1'b0;
        // R1: idle after reset, nothing fires
        idle(40);
        chk("R1 chip_reset", int'(chip_reset), 0);
        chk("R1 bad_key", int'(bad_key), 0);
        chk("R1 nmi seen", int'(nmi_seen), 0);

        // R3: first write with arbitrary key, then full expiry
        do_write(4, 1, 'h2A);
        idle(40);
        chk("R3 bad_key", int'(bad_key), 0);
        chk("R6 nmi seen", int'(nmi_seen), 1);
        chk("R7 chip_reset", int'(chip_reset), 1);
        do_write(50, 1, 'h2A ^ 'h7F);
        idle(20);
        chk("R7 sticky after write", int'(chip_reset), 1);

        // R5: kicks with alternating keys keep it alive
        do_reset();
        k = 'h15;
        do_write(10, 1, k);
        for (int i = 0; i < 6; i++) begin
            idle(30);
            k = k ^ 'h7F;
            do_write(10, 1, k);
        end
        chk("R5 alive after kicks", int'(chip_reset), 0);
        // R4: repeating the same key is rejected
        do_write(10, 1, k);
        chk("R4 bad_key set", int'(bad_key), 1);
        // R8: correct stop halts counting
        k = k ^ 'h7F;
        do_write(0, 0, k);
        idle(200);
        chk("R8 stopped", int'(chip_reset), 0);
        // R8: wrong-key stop is rejected, counter runs out
        k = k ^ 'h7F;
        do_write(3, 1, k);
        do_write(0, 0, k);
        idle(40);
        chk("R8 wrong-key stop ignored", int'(chip_reset), 1);
        chk("R4 bad_key sticky", int'(bad_key), 1);

        // R10: start at 1 and at 0 bite without NMI
        do_reset();
        do_write(1, 1, 'h00);
        idle(12);
        chk("R10 count1 bite", int'(chip_reset), 1);
        chk("R10 no nmi", int'(nmi_seen), 0);
        do_reset();
        do_write(0, 1, 'h05);
        idle(12);
        chk("R10 count0 bite", int'(chip_reset), 1);
        chk("R10 no nmi count0", int'(nmi_seen), 0);

        // R9: write on a tick cycle wins over the decrement
        do_reset();
        do_write(3, 1, 'h11);
        while (m_pc != TC) @(negedge clk);
        do_write(5, 1, 'h11 ^ 'h7F);
        idle(18);
        chk("R9 reload on tick", int'(chip_reset), 0);
        idle(40);
        chk("R9 R6 nmi seen", int'(nmi_seen), 1);
        chk("R9 R7 expiry", int'(chip_reset), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule